// File: doc/BRIEF.md
# Serial Port FIFO Pair with Trigger Flags

This block holds the byte queues that sit between a processor and a serial shifter. One 16-entry queue carries bytes from the processor out towards the transmitter. The other carries bytes arriving from the receiver back to the processor. An 8-bit control register sets a trigger level for each direction, clears either queue on demand, drives a modem-control enable, and can turn on an internal loop-back path.

Two flags tell the processor when to act. The receive-ready flag rises once enough bytes are waiting. The transmit-low flag rises once the outgoing queue has drained to its trigger level. With loop-back on, every byte the shifter takes from the transmit queue lands in the receive queue one cycle later, and the external receive input is ignored. A standby input returns the control register to all zeros.

Top module: `serial_fifo_pair`

## Requirements
- R1: After a synchronous reset, cfg_rdata is 0x00. A write through cfg_we stores cfg_wdata, and cfg_rdata shows the stored value from the next cycle on.
- R2: While standby is high, the control register is forced to 0x00 and writes are ignored. The FIFO contents are kept.
- R3: Each queue holds up to 16 bytes in first-in first-out order. Its count port gives the number of stored bytes. A pop updates the rd_data port on the following cycle.
- R4: rx_ready is high when rx_count is at least the receive level chosen by control bits 7:6: code 0 means 1, code 1 means 4, code 2 means 8, code 3 means 14.
- R5: tx_low is high when tx_count is at most the transmit level chosen by control bits 5:4: code 0 means 8, code 1 means 4, code 2 means 2, code 3 means 1.
- R6: Control bit 2 clears the transmit queue and bit 1 clears the receive queue. A set bit takes effect on the cycle after it is written. While the bit stays 1, the queue stays empty and drops pushes with no overrun. Normal operation resumes once the bit is written back to 0.
- R7: A push into a full queue with no pop in the same cycle is dropped. The matching overrun output is then high for exactly the following cycle.
- R8: A pop from an empty queue leaves its rd_data and its count unchanged.
- R9: While control bit 0 is 1, each byte popped from the transmit queue is pushed into the receive queue one cycle after the pop, and rx_in_valid is ignored.
- R10: mdm_en follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Forces the control register to zero |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| mdm_en | output | 1 | Modem-control enable (bit 3) |
| tx_wr_en | input | 1 | Processor pushes a transmit byte |
| tx_wr_data | input | WIDTH | Transmit byte to push |
| tx_rd_en | input | 1 | Shifter pops a transmit byte |
| tx_rd_data | output | WIDTH | Last byte popped from the transmit queue |
| tx_count | output | CW | Bytes held in the transmit queue |
| tx_low | output | 1 | Transmit queue at or below its trigger level |
| tx_overrun | output | 1 | Transmit push was dropped last cycle |
| rx_in_valid | input | 1 | Shifter delivers a received byte |
| rx_in_data | input | WIDTH | Received byte |
| rx_rd_en | input | 1 | Processor pops a received byte |
| rx_rd_data | output | WIDTH | Last byte popped from the receive queue |
| rx_count | output | CW | Bytes held in the receive queue |
| rx_ready | output | 1 | Receive queue at or above its trigger level |
| rx_overrun | output | 1 | Receive push was dropped last cycle |

## Verification
The assertions check these properties on every cycle: the counts stay within bounds, the control register is zero after reset or standby, a set clear bit empties its queue, the flags hold at the extreme counts, an overrun follows only a full queue, and an empty pop keeps the read data. Three things need the bench's scenarios and its reference queues: the byte order through both queues, the exact trigger level for each code, and the one-cycle loop-back path. Its scenarios also show that external receive bytes are ignored in loop-back mode and that the queues survive standby.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef struct packed {
    logic [1:0] rx_trg;
    logic [1:0] tx_trg;
    logic       mdm_en;
    logic       tx_clr;
    logic       rx_clr;
    logic       loop_en;
  } sfifo_cfg_t;

  // receive level: flag once count reaches this
  function automatic int unsigned rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // transmit level: flag once count drains to this
  function automatic int unsigned tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sfifo_cfg_reg.sv
module sfifo_cfg_reg
  import sfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       standby,
  input  logic       we,
  input  logic [7:0] wdata,
  output sfifo_cfg_t cfg
);

  always_ff @(posedge clk) begin
    if (rst || standby) cfg <= '0;
    else if (we)        cfg <= sfifo_cfg_t'(wdata);
  end

endmodule

// File: rtl/sfifo_buf.sv
module sfifo_buf #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             pop_ok,
  output logic             overrun
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             empty, full, push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop  & ~empty & ~clr;
  assign push_ok = push & ~clr & (~full | pop_ok);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (pop_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else     overrun <= push & ~clr & ~push_ok;
  end

endmodule

// File: rtl/sfifo_level_cmp.sv
module sfifo_level_cmp
  import sfifo_pkg::*;
#(
  parameter int CW    = 5,
  parameter bit IS_RX = 1'b1
) (
  input  logic [1:0]    code,
  input  logic [CW-1:0] count,
  output logic          flag
);

  logic [31:0] cnt32;
  assign cnt32 = {{(32 - CW){1'b0}}, count};

  generate
    if (IS_RX) begin : g_rx
      assign flag = (cnt32 >= rx_level(code));
    end else begin : g_tx
      assign flag = (cnt32 <= tx_level(code));
    end
  endgenerate

endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import sfifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             mdm_en,
  input  logic             tx_wr_en,
  input  logic [WIDTH-1:0] tx_wr_data,
  input  logic             tx_rd_en,
  output logic [WIDTH-1:0] tx_rd_data,
  output logic [CW-1:0]    tx_count,
  output logic             tx_low,
  output logic             tx_overrun,
  input  logic             rx_in_valid,
  input  logic [WIDTH-1:0] rx_in_data,
  input  logic             rx_rd_en,
  output logic [WIDTH-1:0] rx_rd_data,
  output logic [CW-1:0]    rx_count,
  output logic             rx_ready,
  output logic             rx_overrun
);

  sfifo_cfg_t       cfg;
  logic             tx_pop_ok, rx_pop_ok;
  logic             lb_q;
  logic             rx_push;
  logic [WIDTH-1:0] rx_push_data;

  sfifo_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .standby (standby),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg     (cfg)
  );

  assign cfg_rdata = cfg;
  assign mdm_en    = cfg.mdm_en;

  sfifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .clr       (cfg.tx_clr),
    .push      (tx_wr_en),
    .push_data (tx_wr_data),
    .pop       (tx_rd_en),
    .rd_data   (tx_rd_data),
    .count     (tx_count),
    .pop_ok    (tx_pop_ok),
    .overrun   (tx_overrun)
  );

  // loop-back: the popped byte sits in tx_rd_data for one cycle
  always_ff @(posedge clk) begin
    if (rst) lb_q <= 1'b0;
    else     lb_q <= tx_pop_ok & cfg.loop_en;
  end

  assign rx_push      = cfg.loop_en ? lb_q       : rx_in_valid;
  assign rx_push_data = cfg.loop_en ? tx_rd_data : rx_in_data;

  sfifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .clr       (cfg.rx_clr),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_rd_en),
    .rd_data   (rx_rd_data),
    .count     (rx_count),
    .pop_ok    (rx_pop_ok),
    .overrun   (rx_overrun)
  );

  sfifo_level_cmp #(.CW(CW), .IS_RX(1'b1)) u_rx_lvl (
    .code  (cfg.rx_trg),
    .count (rx_count),
    .flag  (rx_ready)
  );

  sfifo_level_cmp #(.CW(CW), .IS_RX(1'b0)) u_tx_lvl (
    .code  (cfg.tx_trg),
    .count (tx_count),
    .flag  (tx_low)
  );

  logic unused_ok;
  assign unused_ok = rx_pop_ok;

endmodule

// File: rtl/serial_fifo_pair_chk.sv
module serial_fifo_pair_chk #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             standby,
  input logic [7:0]       cfg_rdata,
  input logic             tx_rd_en,
  input logic [WIDTH-1:0] tx_rd_data,
  input logic [CW-1:0]    tx_count,
  input logic             tx_low,
  input logic             tx_overrun,
  input logic             rx_rd_en,
  input logic [WIDTH-1:0] rx_rd_data,
  input logic [CW-1:0]    rx_count,
  input logic             rx_ready,
  input logic             rx_overrun
);

  a_r1_cfg_reset: assert property (@(posedge clk) rst |=> cfg_rdata == 8'h00);

  a_r2_standby_zero: assert property (@(posedge clk) disable iff (rst)
    standby |=> cfg_rdata == 8'h00);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  a_r4_rx_flag_top: assert property (@(posedge clk) disable iff (rst)
    (rx_count >= CW'(14)) |-> rx_ready);

  a_r4_rx_flag_zero: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |-> !rx_ready);

  a_r5_tx_flag_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_count == '0) |-> tx_low);

  a_r5_tx_flag_high: assert property (@(posedge clk) disable iff (rst)
    (tx_count > CW'(8)) |-> !tx_low);

  a_r6_tx_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[2] |=> tx_count == '0);

  a_r6_rx_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[1] |=> rx_count == '0);

  a_r7_tx_overrun_full: assert property (@(posedge clk) disable iff (rst)
    tx_overrun |-> $past(tx_count) == CW'(DEPTH));

  a_r7_rx_overrun_full: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> $past(rx_count) == CW'(DEPTH));

  a_r8_tx_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (tx_rd_en && tx_count == '0) |=> $stable(tx_rd_data) && tx_count == '0 || $past(cfg_rdata[2]) == 1'b0 && $stable(tx_rd_data));

  a_r8_rx_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (rx_rd_en && rx_count == '0) |=> $stable(rx_rd_data));

endmodule

bind serial_fifo_pair serial_fifo_pair_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .standby    (standby),
  .cfg_rdata  (cfg_rdata),
  .tx_rd_en   (tx_rd_en),
  .tx_rd_data (tx_rd_data),
  .tx_count   (tx_count),
  .tx_low     (tx_low),
  .tx_overrun (tx_overrun),
  .rx_rd_en   (rx_rd_en),
  .rx_rd_data (rx_rd_data),
  .rx_count   (rx_count),
  .rx_ready   (rx_ready),
  .rx_overrun (rx_overrun)
);

// File: tb/tb_serial_fifo_pair.sv
module tb_serial_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WIDTH      = 8;
  localparam int CW         = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1, standby = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic mdm_en;
  logic tx_wr_en = 1'b0, tx_rd_en = 1'b0, rx_in_valid = 1'b0, rx_rd_en = 1'b0;
  logic [WIDTH-1:0] tx_wr_data = '0, rx_in_data = '0, tx_rd_data, rx_rd_data;
  logic [CW-1:0] tx_count, rx_count;
  logic tx_low, tx_overrun, rx_ready, rx_overrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_fifo_pair #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .standby(standby), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mdm_en(mdm_en),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_rd_en(tx_rd_en),
    .tx_rd_data(tx_rd_data), .tx_count(tx_count), .tx_low(tx_low), .tx_overrun(tx_overrun),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_rd_en(rx_rd_en),
    .rx_rd_data(rx_rd_data), .rx_count(rx_count), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  int checks = 0, fails = 0;
  logic [7:0] tq[$], rq[$];
  logic [7:0] m_cfg = '0, m_txd = '0, m_rxd = '0;
  bit m_lb = 0, m_tovr = 0, m_rovr = 0;

  function automatic bit exp_rx_flag(int cnt, logic [1:0] code);
    int lv [4] = '{1, 4, 8, 14};
    return cnt >= lv[code];
  endfunction

  function automatic bit exp_tx_flag(int cnt, logic [1:0] code);
    int lv [4] = '{8, 4, 2, 1};
    return cnt <= lv[code];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1", "cfg_rdata", int'(cfg_rdata), int'(m_cfg));
    chk("R10", "mdm_en", int'(mdm_en), int'(m_cfg[3]));
    chk("R3", "tx_count", int'(tx_count), tq.size());
    chk("R3", "rx_count", int'(rx_count), rq.size());
    chk("R3", "tx_rd_data", int'(tx_rd_data), int'(m_txd));
    chk("R3", "rx_rd_data", int'(rx_rd_data), int'(m_rxd));
    chk("R5", "tx_low", int'(tx_low), int'(exp_tx_flag(tq.size(), m_cfg[5:4])));
    chk("R4", "rx_ready", int'(rx_ready), int'(exp_rx_flag(rq.size(), m_cfg[7:6])));
    chk("R7", "tx_overrun", int'(tx_overrun), int'(m_tovr));
    chk("R7", "rx_overrun", int'(rx_overrun), int'(m_rovr));
  endtask

  // one clock: drive, update the reference model, sample after the edge
  task automatic cyc(input bit cwe, input logic [7:0] cwd, input bit sb,
                     input bit twe, input logic [7:0] twd, input bit tre,
                     input bit rve, input logic [7:0] rvd, input bit rre);
    bit tclr, rclr, lp, tpop, tpush, rpv, rpop, rpush;
    logic [7:0] rpd;
    cfg_we = cwe; cfg_wdata = cwd; standby = sb;
    tx_wr_en = twe; tx_wr_data = twd; tx_rd_en = tre;
    rx_in_valid = rve; rx_in_data = rvd; rx_rd_en = rre;
    tclr = m_cfg[2]; rclr = m_cfg[1]; lp = m_cfg[0];
    tpop  = tre && tq.size() > 0 && !tclr;
    tpush = twe && !tclr && (tq.size() < DEPTH || tpop);
    rpv   = lp ? m_lb : rve;
    rpd   = lp ? m_txd : rvd;
    rpop  = rre && rq.size() > 0 && !rclr;
    rpush = rpv && !rclr && (rq.size() < DEPTH || rpop);
    m_tovr = twe && !tclr && !tpush;
    m_rovr = rpv && !rclr && !rpush;
    if (tclr) tq.delete();
    else begin
      if (tpop)  m_txd = tq.pop_front();
      if (tpush) tq.push_back(twd);
    end
    if (rclr) rq.delete();
    else begin
      if (rpop)  m_rxd = rq.pop_front();
      if (rpush) rq.push_back(rpd);
    end
    m_lb = tpop && lp;
    if (sb) m_cfg = '0;
    else if (cwe) m_cfg = cwd;
    @(posedge clk); #1;
    cfg_we = 0; standby = 0; tx_wr_en = 0; tx_rd_en = 0; rx_in_valid = 0; rx_rd_en = 0;
    cmp_all();
  endtask

  task automatic idle();
    cyc(0, 8'h00, 0, 0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  task automatic wcfg(input logic [7:0] v);
    cyc(1, v, 0, 0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    chk("R1", "cfg after reset", int'(cfg_rdata), 0);
    chk("R5", "tx_low after reset", int'(tx_low), 1);
    chk("R4", "rx_ready after reset", int'(rx_ready), 0);
    cmp_all();

    // R3, R5, R7: fill transmit queue past full
    wcfg(8'h08);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 1, 8'(8'h30 + i), 0, 0, 0, 0);
    chk("R7", "tx_overrun after 17th push", int'(tx_overrun), 1);
    idle();
    chk("R7", "tx_overrun single cycle", int'(tx_overrun), 0);
    // push and pop together at full is accepted
    cyc(0, 0, 0, 1, 8'hA5, 1, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R8: pop from empty keeps data and count
    hold = tx_rd_data;
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "tx_rd_data on empty pop", int'(tx_rd_data), int'(hold));
    chk("R8", "tx_count on empty pop", int'(tx_count), 0);

    // R4: each receive trigger code, filled from the external input
    for (int c = 0; c < 4; c++) begin
      wcfg(8'(c << 6));
      for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 0, 0, 1, 8'(c * 16 + i), 0);
      for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    end
    // R5: each transmit trigger code
    for (int c = 0; c < 4; c++) begin
      wcfg(8'(c << 4));
      for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 8'(i), 0, 0, 0, 0);
      for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    end

    // R6: clear bits empty the queues and hold them empty
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 8'(i), 0, 1, 8'(i), 0);
    wcfg(8'h06);
    idle();
    chk("R6", "tx_count cleared", int'(tx_count), 0);
    chk("R6", "rx_count cleared", int'(rx_count), 0);
    cyc(0, 0, 0, 1, 8'h11, 0, 1, 8'h22, 0);
    chk("R6", "tx push ignored while clearing", int'(tx_count), 0);
    chk("R6", "no overrun while clearing", int'(tx_overrun), 0);
    wcfg(8'h00);
    cyc(0, 0, 0, 1, 8'h11, 0, 1, 8'h22, 0);
    chk("R6", "tx resumes", int'(tx_count), 1);
    chk("R6", "rx resumes", int'(rx_count), 1);

    // R2: standby zeroes the control register, keeps the queues, blocks writes
    wcfg(8'hF8);
    cyc(1, 8'h30, 1, 0, 0, 0, 0, 0, 0);
    chk("R2", "cfg after standby", int'(cfg_rdata), 0);
    chk("R2", "tx_count kept in standby", int'(tx_count), 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 1);

    // R9: loop-back moves popped bytes, external input ignored
    wcfg(8'h01);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 8'(8'hC0 + i), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 1, 8'hEE, 0);
    idle();
    chk("R9", "rx_count after loop-back", int'(rx_count), 3);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, 8'hEE, 1);
      chk("R9", "looped byte", int'(rx_rd_data), 8'hC0 + i);
    end
    wcfg(8'h00);

    // random traffic with occasional control changes
    for (int n = 0; n < 4000; n++) begin
      bit cwe, sb;
      logic [7:0] cv;
      cwe = ($urandom % 40) == 0;
      cv  = 8'($urandom);
      if (($urandom % 4) != 0) cv[2:1] = 2'b00;
      sb  = ($urandom % 300) == 0;
      cyc(cwe, cv, sb, ($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0,
          ($urandom % 2) == 0, 8'($urandom), ($urandom % 3) == 0);
    end

    summary();
    $finish;
  end

endmodule